// File: doc/BRIEF.md
# Configuration Memory CRC Error Detector

The block watches a read-only configuration memory for upsets while the rest of the chip runs. Once configuration completes it sweeps the memory from the first word to the last, one 32-bit word per clock, and folds each word into a 32-bit CRC. At the end of every sweep it XORs the computed CRC with a reference value and stores the result in a signature register. The signature is zero when the memory is intact. An error output is high whenever the signature is non-zero. The sweep then starts again at once.

The reference lives in a storage register. That register is loaded from the configuration loader when configuration finishes. A serial scan path can also shift a new value into it. This lets test software plant a wrong reference and confirm that the error path works, without stopping the check. A scanned value only takes effect at the start of the next sweep. A one-cycle pulse marks every signature update.

Top module: `cfg_crc_monitor`

## Requirements
- R1: After reset the signature is zero, the error output and the pass pulse are low, the storage register is zero (scan output low) and the memory address is zero.
- R2: A high `cfg_done` loads `cfg_crc` into the storage register and starts checking on the next cycle at address 0. Each clock the address rises by one over all 2^ADDR_W words, then wraps to 0 and the next sweep begins at once. The first pass pulse appears 2^ADDR_W cycles after the load cycle.
- R3: The CRC uses polynomial 0x04C11DB7 with no reflection and no final XOR. It is seeded with 0xFFFFFFFF at the start of every sweep. Each word is consumed in a single clock, bit 31 first.
- R4: At the end of a sweep the signature becomes the computed CRC XOR the reference. It is zero when the two match.
- R5: The error output is high exactly when the signature is non-zero.
- R6: The signature changes only at the end of a sweep and holds its value in between. `pass_done` is high for exactly one cycle, in the cycle in which the new signature is first visible.
- R7: While `scan_shift` is high, each clock the storage register shifts one place toward its MSB and `scan_in` enters at bit 0. `scan_out` always shows storage bit 31, so the old value leaves MSB first.
- R8: Scanning does not pause or restart checking: the address keeps advancing and sweeps keep completing.
- R9: A sweep uses the reference held in storage at its first word. Scan changes made during a sweep first affect the sweep that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Configuration-complete strobe; loads the reference and starts checking |
| cfg_crc | input | 32 | Precomputed reference CRC taken on `cfg_done` |
| scan_shift | input | 1 | Shift enable for the storage register scan chain |
| scan_in | input | 1 | Serial data into storage bit 0 |
| scan_out | output | 1 | Storage bit 31 |
| mem_addr | output | ADDR_W | Word address into the configuration memory |
| mem_data | input | 32 | Word read at `mem_addr`, valid in the same cycle |
| signature | output | 32 | Signature register: computed CRC XOR reference |
| crc_error | output | 1 | High when the signature is non-zero |
| pass_done | output | 1 | One-cycle pulse on each signature update |

## Verification
The bench goes through several memory contents: all zeros, all ones, and two arithmetic fills. For each it checks that a matching reference gives a zero signature on two sweeps in a row. A design that failed to reseed would show a non-zero signature on the second sweep. A deliberately wrong reference must give back exactly the XOR difference. This catches a wrong polynomial, bit order or compare. The bench also corrupts a memory word between sweeps. It then checks that the old signature holds until the next sweep ends, which exposes designs that update early. Finally it scans in a new reference while a sweep is in progress. It checks that the old value comes out MSB first, that the address keeps moving, and that the new value changes the signature only one sweep later. A design that used storage live would flag an error one sweep too soon.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;
    localparam int unsigned CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
endpackage

// File: rtl/cfg_crc_engine.sv
// One full memory word folded into the running CRC in a single cycle,
// most significant data bit first, unrolled as a chain of bit steps.
module cfg_crc_engine
    import cfg_crc_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic [CRC_W-1:0] word,
    output logic [CRC_W-1:0] crc_out
);
    logic [CRC_W:0][CRC_W-1:0] chain;

    assign chain[0] = crc_in;

    for (genvar b = 0; b < CRC_W; b++) begin : g_bit
        logic fb;
        assign fb = chain[b][CRC_W-1] ^ word[CRC_W-1-b];
        assign chain[b+1] = {chain[b][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    assign crc_out = chain[CRC_W];
endmodule

// File: rtl/cfg_crc_storage.sv
// Reference register: parallel load at configuration end, serial scan otherwise.
module cfg_crc_storage
    import cfg_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CRC_W-1:0] load_val,
    input  logic             shift,
    input  logic             sin,
    output logic [CRC_W-1:0] value,
    output logic             sout
);
    logic [CRC_W-1:0] store_d, store_q;

    always_comb begin
        store_d = store_q;
        if (load) begin
            store_d = load_val;
        end else if (shift) begin
            store_d = {store_q[CRC_W-2:0], sin};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign value = store_q;
    assign sout  = store_q[CRC_W-1];
endmodule

// File: rtl/cfg_crc_sequencer.sv
// Walks the memory address space in an endless loop once started.
module cfg_crc_sequencer #(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              active,
    output logic [ADDR_W-1:0] addr,
    output logic              first,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.active = 1'b1;
            seq_d.addr   = '0;
        end else if (seq_q.active) begin
            seq_d.addr = seq_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active = seq_q.active;
    assign addr   = seq_q.addr;
    assign first  = seq_q.active && (seq_q.addr == '0);
    assign last   = seq_q.active && (seq_q.addr == LAST_ADDR);
endmodule

// File: rtl/cfg_crc_monitor.sv
module cfg_crc_monitor
    import cfg_crc_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic [31:0]       cfg_crc,
    input  logic              scan_shift,
    input  logic              scan_in,
    output logic              scan_out,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_data,
    output logic [31:0]       signature,
    output logic              crc_error,
    output logic              pass_done
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] refv;
        logic [CRC_W-1:0] sig;
        logic             done;
    } mon_t;

    mon_t mon_d, mon_q;

    logic             seq_active;
    logic             seq_first;
    logic             seq_last;
    logic [CRC_W-1:0] store_val;
    logic [CRC_W-1:0] crc_start;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] ref_use;

    cfg_crc_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (cfg_done),
        .active (seq_active),
        .addr   (mem_addr),
        .first  (seq_first),
        .last   (seq_last)
    );

    cfg_crc_storage u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_done),
        .load_val (cfg_crc),
        .shift    (scan_shift),
        .sin      (scan_in),
        .value    (store_val),
        .sout     (scan_out)
    );

    assign crc_start = seq_first ? CRC_SEED : mon_q.crc;
    assign ref_use   = seq_first ? store_val : mon_q.refv;

    cfg_crc_engine u_eng (
        .crc_in  (crc_start),
        .word    (mem_data),
        .crc_out (crc_next)
    );

    always_comb begin
        mon_d      = mon_q;
        mon_d.done = 1'b0;
        if (seq_active && !cfg_done) begin
            mon_d.crc = crc_next;
            if (seq_first) begin
                mon_d.refv = store_val;
            end
            if (seq_last) begin
                mon_d.sig  = crc_next ^ ref_use;
                mon_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign signature = mon_q.sig;
    assign crc_error = |mon_q.sig;
    assign pass_done = mon_q.done;
endmodule

// File: rtl/cfg_crc_monitor_chk.sv
module cfg_crc_monitor_chk #(
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_done,
    input logic              scan_shift,
    input logic              scan_out,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       signature,
    input logic              crc_error,
    input logic              pass_done,
    input logic              active
);
    a_r6_sig_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_done |-> $stable(signature));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    a_r5_err_rise_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_error) |-> pass_done);

    a_r5_err_fall_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crc_error) |-> pass_done);

    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(cfg_done))
            |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    a_r2_pass_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (mem_addr == '0));

    a_r7_scan_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_shift && !cfg_done) |=> $stable(scan_out));

    a_r8_scan_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (active && scan_shift) |=> active);
endmodule

bind cfg_crc_monitor cfg_crc_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_done   (cfg_done),
    .scan_shift (scan_shift),
    .scan_out   (scan_out),
    .mem_addr   (mem_addr),
    .signature  (signature),
    .crc_error  (crc_error),
    .pass_done  (pass_done),
    .active     (seq_active)
);

// File: tb/cfg_crc_monitor_bench.sv
`timescale 1ns/1ps
module cfg_crc_monitor_bench;
    localparam int unsigned AW    = 6;
    localparam int unsigned DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_done = 1'b0;
    logic [31:0]   cfg_crc = '0;
    logic          scan_shift = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_data;
    logic [31:0]   signature;
    logic          crc_error;
    logic          pass_done;

    logic [31:0] mem [0:DEPTH-1];
    assign mem_data = mem[mem_addr];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    cfg_crc_monitor #(.ADDR_W(AW)) u_cfg_crc_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_done   (cfg_done),
        .cfg_crc    (cfg_crc),
        .scan_shift (scan_shift),
        .scan_in    (scan_in),
        .scan_out   (scan_out),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .signature  (signature),
        .crc_error  (crc_error),
        .pass_done  (pass_done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_crc();
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 31; b >= 0; b--) begin
                logic fb;
                fb = c[31] ^ mem[a][b];
                c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        return c;
    endfunction

    task automatic fill(input int p);
        for (int a = 0; a < DEPTH; a++) begin
            case (p)
                0: mem[a] = 32'h0;
                1: mem[a] = 32'hFFFF_FFFF;
                2: mem[a] = 32'(a) * 32'h0101_0101 ^ 32'hA5A5_0000;
                default: mem[a] = 32'(a + 1) * 32'h9E37_79B9;
            endcase
        end
    endtask

    // returns number of negedges until pass_done is seen
    task automatic wait_pass(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pass_done && n < 4 * DEPTH);
    endtask

    task automatic configure(input logic [31:0] refv);
        @(negedge clk);
        cfg_crc  = refv;
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    initial begin
        int n;
        logic [31:0] good;
        logic [31:0] newref;
        logic [AW-1:0] a0;

        fill(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(signature == 0, "R1 signature", signature, 0);
        chk(!crc_error && !pass_done, "R1 flags", {crc_error, pass_done}, 0);
        chk(!scan_out && mem_addr == 0, "R1 storage/addr", {scan_out, mem_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pass_done && mem_addr == 0, "R1 idle before cfg_done", {pass_done, mem_addr}, 0);

        for (int p = 0; p < 4; p++) begin
            fill(p);
            good = mem_crc();
            configure(good);
            // R2: sweep starts at address 0 and counts upward
            chk(mem_addr == 0, "R2 start address", 32'(mem_addr), 0);
            @(negedge clk);
            chk(mem_addr == 1, "R2 address step", 32'(mem_addr), 1);
            wait_pass(n);
            chk(n + 1 == DEPTH, "R2 pass length", n + 1, DEPTH);
            chk(signature == 0, "R4 matching ref gives zero", signature, 0);
            chk(!crc_error, "R5 no error when zero", 32'(crc_error), 0);
            wait_pass(n);
            chk(n == DEPTH, "R2 continuous sweeps", n, DEPTH);
            chk(signature == 0, "R3 seed restored each sweep", signature, 0);
            @(negedge clk);
            chk(!pass_done, "R6 pulse one cycle", 32'(pass_done), 0);

            // wrong reference: signature equals the XOR difference
            configure(good ^ (32'h1 << (p * 9 + 2)));
            wait_pass(n);
            chk(signature == (32'h1 << (p * 9 + 2)), "R4 mismatch difference",
                signature, 32'h1 << (p * 9 + 2));
            chk(crc_error, "R5 error on non-zero", 32'(crc_error), 1);
        end

        // R6: memory upset between sweeps, signature holds until sweep end
        fill(2);
        good = mem_crc();
        configure(good);
        wait_pass(n);
        chk(signature == 0, "R4 clean before upset", signature, 0);
        mem[5] = mem[5] ^ 32'h0000_0400;
        repeat (10) @(negedge clk);
        chk(signature == 0 && !pass_done, "R6 holds mid-sweep", signature, 0);
        wait_pass(n);
        chk(signature == (mem_crc() ^ good), "R4 upset detected", signature, mem_crc() ^ good);
        chk(crc_error, "R5 upset raises error", 32'(crc_error), 1);
        mem[5] = mem[5] ^ 32'h0000_0400;
        wait_pass(n);
        chk(signature == 0 && !crc_error, "R6 error clears next sweep", signature, 0);

        // R7, R8, R9: scan in a new reference during a sweep
        newref = good ^ 32'h0000_0100;
        a0 = mem_addr;
        chk(a0 == 0, "R9 scan begins at sweep start", 32'(a0), 0);
        for (int i = 0; i < 32; i++) begin
            chk(scan_out == good[31-i], "R7 old value leaves MSB first",
                32'(scan_out), 32'(good[31-i]));
            scan_shift = 1'b1;
            scan_in    = newref[31-i];
            if (i == 31) begin
                chk(mem_addr == AW'(31), "R8 address advances while scanning",
                    32'(mem_addr), 31);
            end
            @(negedge clk);
        end
        scan_shift = 1'b0;
        scan_in    = 1'b0;
        chk(scan_out == newref[31], "R7 new MSB at scan output", 32'(scan_out), 32'(newref[31]));
        chk(mem_addr == AW'(32), "R8 sweep not restarted", 32'(mem_addr), 32);
        wait_pass(n);
        chk(signature == 0, "R9 sweep in progress keeps old ref", signature, 0);
        wait_pass(n);
        chk(n == DEPTH && signature == 32'h0000_0100, "R9 next sweep uses new ref",
            signature, 32'h0000_0100);
        chk(crc_error, "R5 injected error visible", 32'(crc_error), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule